// File: doc/BRIEF.md
# Add Scheduler with Partial-Operand Rewriting

This block is a small out-of-order window for two-operand 32-bit additions. Each operation enters with a destination tag and two sources. Each source is either a constant that is already known or a tag that is still pending. Entries pick up operand values from two places: an external completion port (for example, loads returning) and the window's own broadcast bus. When both operands are known, the entry issues. It puts the sum on the bus under its destination tag and frees itself.

Additions often wait for a second operand long after the first one has arrived. To shorten that wait, an entry that holds one known value and one pending tag may announce its partial form on the bus without waiting: "my tag equals pending tag P plus constant K". Any entry waiting on that tag, whose other operand is already a constant, rewrites itself. It then waits on P directly and folds K into its stored constant. A chain of dependent adds therefore collapses to a single dataflow level. This reacts only to the order in which values actually arrive. No arrival times are predicted.

The bus carries one event per cycle. A result always wins over a partial-form announcement.

Top module: `skew_add_sched`

## Requirements
- R1: After a synchronous active-low reset, the window is empty and `bc_valid` is low.
- R2: A source presented at allocation as a pending tag is captured in the same cycle if that tag appears on the completion port or as a result on the bus. An entry whose operands are both known at allocation issues in the following cycle.
- R3: An entry captures a completion or bus result whose tag matches a pending source. In the cycle after both operands are known, it broadcasts `bc_rewrite=0`, `bc_tag` = its destination tag and `bc_val` = the 32-bit wrapping sum. It then leaves the window.
- R4: When several entries are ready in the same cycle, the one allocated earliest issues first, whatever slot it occupies. The others follow on later cycles, one per cycle.
- R5: An entry with exactly one known operand broadcasts its partial form only in a cycle in which no entry is ready. The partial form is `bc_rewrite=1`, `bc_tag` = its destination, `bc_src_tag` = its pending tag and `bc_val` = its known value.
- R6: An entry receives a partial form whose tag matches a pending source in either operand position, while its other operand is a known constant. It then waits on `bc_src_tag` instead and adds `bc_val` to that constant. As a result, it can issue as soon as that older tag completes, without waiting for the intermediate result.
- R7: A partial form may arrive in the same cycle as the completion of its pending tag. In that case the rewriting entry captures the completed value directly and does not miss it.
- R8: An entry broadcasts its partial form at most once while it occupies the window.
- R9: For any order and spacing of external completions, every result tag carries the same value as a plain sequential evaluation of the operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate one operation this cycle (dropped if the window is full) |
| alloc_dst | input | 6 | Destination tag of the new operation |
| alloc_a_const | input | 1 | First source is a known constant |
| alloc_a_tag | input | 6 | First source tag when pending |
| alloc_a_val | input | 32 | First source value when constant |
| alloc_b_const | input | 1 | Second source is a known constant |
| alloc_b_tag | input | 6 | Second source tag when pending |
| alloc_b_val | input | 32 | Second source value when constant |
| cpl_valid | input | 1 | External value completes this cycle |
| cpl_tag | input | 6 | Tag of the completed value |
| cpl_val | input | 32 | Completed value |
| bc_valid | output | 1 | Bus carries an event this cycle |
| bc_rewrite | output | 1 | 1 = partial form, 0 = result |
| bc_tag | output | 6 | Destination tag of the broadcasting entry |
| bc_val | output | 32 | Sum (result) or known constant (partial form) |
| bc_src_tag | output | 6 | Pending tag of a partial form; 0 for results |

## Verification
Single adds are tried in four ways:
- with a source completing in its allocation cycle;
- with a wrapping sum;
- with two equally ready entries, where the older one sits in the higher slot, so that age order is distinguished from slot order;
- with a completion driven in exactly the cycle a partial form appears, which exposes a lost wake-up.

A two-level chain is run with its loads completing last-to-first, in both operand positions. There, the rewritten consumer must issue before its own producer. Without rewriting, that order is impossible.

Random completion orders and gaps over a five-operation graph compare every result with a sequential evaluation.

// File: rtl/sched_pkg.sv
// Shared widths and operand record for the partial-operand add scheduler.
package sched_pkg;
    localparam int unsigned DW = 32;  // operand width, wraps on overflow
    localparam int unsigned TW = 6;   // tag width

    // One source operand: either a known value or a pending tag.
    typedef struct packed {
        logic          known;
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } opnd_t;
endpackage

// File: rtl/sched_slot.sv
// One window entry. Holds a destination tag and two operands, captures
// values from the completion port and the result bus, and reassociates
// itself when a partial form on the bus names its pending source.
// Assumes: alloc_en only when empty; issue_en only when ready_o; fire_en only when cand_o.
module sched_slot
    import sched_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_en,
    input  logic [TW-1:0]   alloc_dst,
    input  opnd_t [1:0]     alloc_ops,
    input  logic            cpl_v,
    input  logic [TW-1:0]   cpl_tag,
    input  logic [DW-1:0]   cpl_val,
    input  logic            bus_v,
    input  logic            bus_rw,
    input  logic [TW-1:0]   bus_tag,
    input  logic [DW-1:0]   bus_val,
    input  logic [TW-1:0]   bus_ptag,
    input  logic            issue_en,
    input  logic            fire_en,
    output logic            valid_o,
    output logic            ready_o,
    output logic            cand_o,
    output logic [TW-1:0]   dst_o,
    output logic [DW-1:0]   sum_o,
    output logic [TW-1:0]   ptag_o,
    output logic [DW-1:0]   kval_o
);
    logic          valid_q;
    logic          fired_q;
    logic [TW-1:0] dst_q;
    opnd_t [1:0]   ops_q;
    opnd_t [1:0]   ops_d;

    // Next operand state: capture, wake-up and reassociation.
    always_comb begin
        ops_d = ops_q;
        for (int i = 0; i < 2; i++) begin
            if (alloc_en) begin
                ops_d[i] = alloc_ops[i];
                if (!alloc_ops[i].known) begin
                    if (cpl_v && cpl_tag == alloc_ops[i].tag) begin
                        ops_d[i].known = 1'b1;
                        ops_d[i].val   = cpl_val;
                    end else if (bus_v && !bus_rw && bus_tag == alloc_ops[i].tag) begin
                        ops_d[i].known = 1'b1;
                        ops_d[i].val   = bus_val;
                    end
                end
            end else if (valid_q && !ops_q[i].known) begin
                if (cpl_v && cpl_tag == ops_q[i].tag) begin
                    ops_d[i].known = 1'b1;
                    ops_d[i].val   = cpl_val;
                end else if (bus_v && !bus_rw && bus_tag == ops_q[i].tag) begin
                    ops_d[i].known = 1'b1;
                    ops_d[i].val   = bus_val;
                end else if (bus_v && bus_rw && bus_tag == ops_q[i].tag && ops_q[1-i].known) begin
                    ops_d[1-i].val = ops_q[1-i].val + bus_val;
                    if (cpl_v && cpl_tag == bus_ptag) begin
                        ops_d[i].known = 1'b1;
                        ops_d[i].val   = cpl_val;
                    end else begin
                        ops_d[i].tag = bus_ptag;
                    end
                end
            end
        end
    end

    // Occupancy, one-shot partial-form flag and operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            fired_q <= 1'b0;
            dst_q   <= '0;
            ops_q   <= '0;
        end else begin
            ops_q <= ops_d;
            if (alloc_en) begin
                valid_q <= 1'b1;
                fired_q <= 1'b0;
                dst_q   <= alloc_dst;
            end else begin
                if (issue_en) valid_q <= 1'b0;
                if (fire_en)  fired_q <= 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
    assign ready_o = valid_q && ops_q[0].known && ops_q[1].known;
    assign cand_o  = valid_q && !fired_q && (ops_q[0].known ^ ops_q[1].known);
    assign dst_o   = dst_q;
    assign sum_o   = ops_q[0].val + ops_q[1].val;
    assign ptag_o  = ops_q[0].known ? ops_q[1].tag : ops_q[0].tag;
    assign kval_o  = ops_q[0].known ? ops_q[0].val : ops_q[1].val;

    // R8: a partial form is never granted twice to one occupancy.
    a_r8_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        fire_en |-> !fired_q);
    // R3: an issued entry leaves the window.
    a_r3_issue_frees: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |=> !valid_q);
    // R2: allocation only targets an empty entry.
    a_r2_alloc_empty: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !valid_q);
    // R6: a known operand stays known while the entry waits.
    a_r6_known_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !alloc_en && !issue_en && ops_q[0].known) |=> ops_q[0].known);
endmodule

// File: rtl/sched_age_pick.sv
// Age-ordered arbiter. Tracks allocation order in an age matrix and grants
// the bus to the oldest ready entry, or, if none is ready, to the oldest
// partial-form candidate. Assumes alloc_oh is one-hot or zero.
module sched_age_pick #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_oh,
    input  logic [N-1:0] valid,
    input  logic [N-1:0] ready,
    input  logic [N-1:0] cand,
    output logic [N-1:0] res_gnt,
    output logic [N-1:0] rw_gnt
);
    // older_q[i][j] set: entry j was allocated before entry i.
    logic [N-1:0] older_q [N];

    // Grant selection: results win, oldest first.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            res_gnt[i] = ready[i] && !(|(older_q[i] & ready));
            rw_gnt[i]  = !(|ready) && cand[i] && !(|(older_q[i] & cand));
        end
    end

    // Age matrix update on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc_oh[i])      older_q[i][j] <= valid[j] && (i != j);
                    else if (alloc_oh[j]) older_q[i][j] <= 1'b0;
                end
            end
        end
    end

    // R4: at most one result grant per cycle.
    a_r4_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_gnt));
    // R5: partial forms only on an otherwise idle bus, one at a time.
    a_r5_rw_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (|rw_gnt) |-> ($onehot0(rw_gnt) && !(|res_gnt)));
    // R4: a granted result always belongs to a ready entry.
    a_r4_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (res_gnt & ~ready) == '0);
endmodule

// File: rtl/skew_add_sched.sv
// Top of the partial-operand add scheduler. Allocates into the lowest free
// entry, drives the single broadcast bus from the granted entry and feeds
// the bus back to every entry for capture and reassociation.
// Assumes destination tags in the window are unique and that sources
// already produced before allocation are supplied as constants.
module skew_add_sched
    import sched_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [5:0]    alloc_dst,
    input  logic          alloc_a_const,
    input  logic [5:0]    alloc_a_tag,
    input  logic [31:0]   alloc_a_val,
    input  logic          alloc_b_const,
    input  logic [5:0]    alloc_b_tag,
    input  logic [31:0]   alloc_b_val,
    input  logic          cpl_valid,
    input  logic [5:0]    cpl_tag,
    input  logic [31:0]   cpl_val,
    output logic          bc_valid,
    output logic          bc_rewrite,
    output logic [5:0]    bc_tag,
    output logic [31:0]   bc_val,
    output logic [5:0]    bc_src_tag
);
    localparam int unsigned N = NUM_ENTRIES;

    logic [N-1:0]  slot_valid, slot_ready, slot_cand;
    logic [N-1:0]  alloc_oh, res_gnt, rw_gnt;
    logic [TW-1:0] slot_dst  [N];
    logic [TW-1:0] slot_ptag [N];
    logic [DW-1:0] slot_sum  [N];
    logic [DW-1:0] slot_kval [N];
    opnd_t [1:0]   alloc_ops;

    assign alloc_ops[0] = '{known: alloc_a_const, tag: alloc_a_tag, val: alloc_a_val};
    assign alloc_ops[1] = '{known: alloc_b_const, tag: alloc_b_tag, val: alloc_b_val};

    // Lowest free entry receives the allocation.
    always_comb begin
        logic found;
        found    = 1'b0;
        alloc_oh = '0;
        for (int i = 0; i < N; i++) begin
            if (!slot_valid[i] && !found) begin
                alloc_oh[i] = alloc_valid;
                found       = 1'b1;
            end
        end
    end

    // Bus driven by the granted entry.
    always_comb begin
        bc_valid   = (|res_gnt) || (|rw_gnt);
        bc_rewrite = !(|res_gnt) && (|rw_gnt);
        bc_tag     = '0;
        bc_val     = '0;
        bc_src_tag = '0;
        for (int i = 0; i < N; i++) begin
            if (res_gnt[i]) begin
                bc_tag = slot_dst[i];
                bc_val = slot_sum[i];
            end else if (rw_gnt[i]) begin
                bc_tag     = slot_dst[i];
                bc_val     = slot_kval[i];
                bc_src_tag = slot_ptag[i];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        sched_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_en (alloc_oh[g]),
            .alloc_dst(alloc_dst),
            .alloc_ops(alloc_ops),
            .cpl_v    (cpl_valid),
            .cpl_tag  (cpl_tag),
            .cpl_val  (cpl_val),
            .bus_v    (bc_valid),
            .bus_rw   (bc_rewrite),
            .bus_tag  (bc_tag),
            .bus_val  (bc_val),
            .bus_ptag (bc_src_tag),
            .issue_en (res_gnt[g]),
            .fire_en  (rw_gnt[g]),
            .valid_o  (slot_valid[g]),
            .ready_o  (slot_ready[g]),
            .cand_o   (slot_cand[g]),
            .dst_o    (slot_dst[g]),
            .sum_o    (slot_sum[g]),
            .ptag_o   (slot_ptag[g]),
            .kval_o   (slot_kval[g])
        );
    end

    sched_age_pick #(.N(N)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_oh(alloc_oh),
        .valid   (slot_valid),
        .ready   (slot_ready),
        .cand    (slot_cand),
        .res_gnt (res_gnt),
        .rw_gnt  (rw_gnt)
    );

    // R1: the bus is idle in the cycle after reset.
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !bc_valid);
    // R3: a result broadcast is followed by no repeat of the same tag.
    a_r3_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && !bc_rewrite) |=> !(bc_valid && !bc_rewrite && bc_tag == $past(bc_tag)));
endmodule

// File: tb/test_skew_add_sched.sv
`timescale 1ns/1ps
module test_skew_add_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [5:0]  alloc_dst = '0;
    logic        alloc_a_const = 1'b0, alloc_b_const = 1'b0;
    logic [5:0]  alloc_a_tag = '0, alloc_b_tag = '0;
    logic [31:0] alloc_a_val = '0, alloc_b_val = '0;
    logic        cpl_valid = 1'b0;
    logic [5:0]  cpl_tag = '0;
    logic [31:0] cpl_val = '0;
    logic        bc_valid, bc_rewrite;
    logic [5:0]  bc_tag, bc_src_tag;
    logic [31:0] bc_val;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Broadcast log, indexed by tag.
    bit          seen   [64];
    int          dups   [64];
    logic [31:0] rval   [64];
    int          rcyc   [64];
    int          rw_cnt [64];
    logic [5:0]  rw_pt  [64];
    logic [31:0] rw_k   [64];

    skew_add_sched i_skew_add_sched (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dst(alloc_dst),
        .alloc_a_const(alloc_a_const), .alloc_a_tag(alloc_a_tag), .alloc_a_val(alloc_a_val),
        .alloc_b_const(alloc_b_const), .alloc_b_tag(alloc_b_tag), .alloc_b_val(alloc_b_val),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_val(cpl_val),
        .bc_valid(bc_valid), .bc_rewrite(bc_rewrite), .bc_tag(bc_tag),
        .bc_val(bc_val), .bc_src_tag(bc_src_tag)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Cycle count and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            summary();
            $finish;
        end
    end

    // Record every bus event away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && bc_valid) begin
            if (!bc_rewrite) begin
                if (seen[bc_tag]) dups[bc_tag]++;
                seen[bc_tag] = 1'b1;
                rval[bc_tag] = bc_val;
                rcyc[bc_tag] = cyc;
            end else begin
                rw_cnt[bc_tag]++;
                rw_pt[bc_tag] = bc_src_tag;
                rw_k[bc_tag]  = bc_val;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int t = 0; t < 64; t++) begin
            seen[t] = 0; dups[t] = 0; rval[t] = '0; rcyc[t] = 0;
            rw_cnt[t] = 0; rw_pt[t] = '0; rw_k[t] = '0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_alloc(input logic [5:0] dst,
                            input bit ac, input logic [5:0] at, input logic [31:0] av,
                            input bit bk, input logic [5:0] bt, input logic [31:0] bv);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_dst = dst;
        alloc_a_const = ac; alloc_a_tag = at; alloc_a_val = av;
        alloc_b_const = bk; alloc_b_tag = bt; alloc_b_val = bv;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_cpl(input logic [5:0] tag, input logic [31:0] val);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = tag; cpl_val = val;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic expect_result(input logic [5:0] tag, input logic [31:0] exp, input string req);
        check(seen[tag] && dups[tag] == 0, req, {26'd0, tag}, {26'd0, tag});
        check(rval[tag] == exp, req, rval[tag], exp);
    endtask

    // R1: idle bus after reset.
    task automatic t_reset();
        idle(1);
        check(bc_valid == 1'b0, "R1 bus idle after reset", {31'd0, bc_valid}, 32'd0);
    endtask

    // R2: completion in the allocation cycle is captured; issue next cycle.
    task automatic t_alloc_capture();
        clear_log();
        @(negedge clk);
        alloc_valid = 1'b1; alloc_dst = 6'd14;
        alloc_a_const = 1'b1; alloc_a_val = 32'd5; alloc_a_tag = '0;
        alloc_b_const = 1'b0; alloc_b_tag = 6'd50; alloc_b_val = '0;
        cpl_valid = 1'b1; cpl_tag = 6'd50; cpl_val = 32'd9;
        @(negedge clk);
        alloc_valid = 1'b0; cpl_valid = 1'b0;
        check(bc_valid && !bc_rewrite && bc_tag == 6'd14, "R2 issue one cycle after capture",
              {26'd0, bc_tag}, 32'd14);
        check(bc_val == 32'd14, "R2 captured sum", bc_val, 32'd14);
        idle(3);
    endtask

    // R3, R5, R8: single add with wrapping sum; partial form fires exactly once.
    task automatic t_basic_wrap();
        clear_log();
        do_alloc(6'd11, 1'b1, 6'd0, 32'hFFFF_FFF0, 1'b0, 6'd12, 32'd0);
        idle(10);
        check(rw_cnt[11] == 1, "R8 partial form fired once", rw_cnt[11], 32'd1);
        check(rw_pt[11] == 6'd12, "R5 partial form pending tag", {26'd0, rw_pt[11]}, 32'd12);
        check(rw_k[11] == 32'hFFFF_FFF0, "R5 partial form constant", rw_k[11], 32'hFFFF_FFF0);
        check(!seen[11], "R3 no issue before operand", {31'd0, seen[11]}, 32'd0);
        do_cpl(6'd12, 32'h20);
        check(bc_valid && !bc_rewrite && bc_tag == 6'd11 && bc_val == 32'h10,
              "R3 wrapped sum next cycle", bc_val, 32'h10);
        idle(3);
    endtask

    // R4: older entry in a higher slot issues before a younger one in a lower slot.
    task automatic t_age_order();
        clear_log();
        do_alloc(6'd60, 1'b0, 6'd61, 0, 1'b0, 6'd62, 0);   // filler, slot 0
        do_alloc(6'd20, 1'b0, 6'd2, 0, 1'b0, 6'd3, 0);      // older, slot 1
        do_cpl(6'd61, 32'd1);
        idle(2);
        do_cpl(6'd62, 32'd2);
        idle(3);
        expect_result(6'd60, 32'd3, "R3 filler result");
        do_alloc(6'd21, 1'b0, 6'd2, 0, 1'b0, 6'd3, 0);      // younger, slot 0
        do_cpl(6'd2, 32'd100);
        idle(4);
        do_cpl(6'd3, 32'd1);
        idle(4);
        expect_result(6'd20, 32'd101, "R4 older value");
        expect_result(6'd21, 32'd101, "R4 younger value");
        check(rcyc[21] == rcyc[20] + 1, "R4 oldest ready first", rcyc[21] - rcyc[20], 32'd1);
    endtask

    // R5, R6: loads complete last-to-first; the consumer is flattened.
    task automatic t_flatten(input bit swap);
        logic [31:0] a, b, c;
        clear_log();
        a = 32'h1000_0001; b = 32'h0000_0200; c = 32'hFFFF_FF00;
        if (swap) do_alloc(6'd35, 1'b0, 6'd33, 0, 1'b0, 6'd34, 0);
        else      do_alloc(6'd35, 1'b0, 6'd34, 0, 1'b0, 6'd33, 0);
        do_alloc(6'd34, 1'b0, 6'd31, 0, 1'b0, 6'd32, 0);
        do_cpl(6'd33, c);
        idle(4);
        do_cpl(6'd32, b);
        idle(4);
        check(rw_cnt[34] == 1 && rw_pt[34] == 6'd31 && rw_k[34] == b,
              swap ? "R5 producer partial form (slot 1)" : "R5 producer partial form (slot 0)",
              rw_k[34], b);
        check(!seen[34] && !seen[35], "R6 nothing issues before last load",
              {30'd0, seen[34], seen[35]}, 32'd0);
        do_cpl(6'd31, a);
        idle(4);
        expect_result(6'd34, a + b, "R6 producer value");
        expect_result(6'd35, a + b + c, swap ? "R6 rewritten consumer (slot 1)" : "R6 rewritten consumer (slot 0)");
        check(rcyc[35] < rcyc[34], "R6 consumer issues at producer level, oldest first",
              rcyc[35], rcyc[34]);
    endtask

    // R7: completion of the pending tag in the same cycle as the partial form.
    task automatic t_race();
        bit hit;
        clear_log();
        hit = 1'b0;
        do_alloc(6'd42, 1'b0, 6'd41, 0, 1'b1, 6'd0, 32'd4);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_dst = 6'd41;
        alloc_a_const = 1'b0; alloc_a_tag = 6'd40; alloc_a_val = '0;
        alloc_b_const = 1'b1; alloc_b_tag = '0; alloc_b_val = 32'd3;
        for (int k = 0; k < 12 && !hit; k++) begin
            @(negedge clk);
            alloc_valid = 1'b0;
            cpl_valid = 1'b0;
            if (bc_valid && bc_rewrite && bc_tag == 6'd41) begin
                cpl_valid = 1'b1; cpl_tag = 6'd40; cpl_val = 32'd50;
                hit = 1'b1;
            end
        end
        @(negedge clk);
        cpl_valid = 1'b0;
        check(hit, "R7 partial form observed", {31'd0, hit}, 32'd1);
        idle(4);
        expect_result(6'd42, 32'd57, "R7 same-cycle completion kept");
        expect_result(6'd41, 32'd53, "R7 producer value");
    endtask

    // R9: random completion orders and gaps against sequential evaluation.
    task automatic t_random(input int trials);
        for (int t = 0; t < trials; t++) begin
            logic [31:0] lv [4];
            int          ord [4];
            logic [31:0] e10, e11, e12, e13, e14;
            clear_log();
            for (int k = 0; k < 4; k++) begin lv[k] = $urandom; ord[k] = k; end
            for (int k = 3; k > 0; k--) begin
                int j; int tmp;
                j = $urandom_range(k, 0);
                tmp = ord[k]; ord[k] = ord[j]; ord[j] = tmp;
            end
            e10 = lv[0] + lv[1];
            e11 = lv[2] + e10;
            e12 = e11 + 32'd7;
            e13 = e12 + lv[3];
            e14 = e13 + e10;
            do_alloc(6'd10, 1'b0, 6'd1, 0, 1'b0, 6'd2, 0);
            do_alloc(6'd11, 1'b0, 6'd3, 0, 1'b0, 6'd10, 0);
            do_alloc(6'd12, 1'b0, 6'd11, 0, 1'b1, 6'd0, 32'd7);
            do_alloc(6'd13, 1'b0, 6'd12, 0, 1'b0, 6'd4, 0);
            do_alloc(6'd14, 1'b0, 6'd13, 0, 1'b0, 6'd10, 0);
            for (int k = 0; k < 4; k++) begin
                do_cpl(6'(ord[k] + 1), lv[ord[k]]);
                idle($urandom_range(3, 0));
            end
            idle(12);
            expect_result(6'd10, e10, "R9 tag 10");
            expect_result(6'd11, e11, "R9 tag 11");
            expect_result(6'd12, e12, "R9 tag 12");
            expect_result(6'd13, e13, "R9 tag 13");
            expect_result(6'd14, e14, "R9 tag 14");
        end
    endtask

    initial begin
        clear_log();
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_alloc_capture();
        t_basic_wrap();
        t_age_order();
        t_flatten(1'b0);
        t_flatten(1'b1);
        t_race();
        t_random(8);
        idle(2);
        summary();
        $finish;
    end
endmodule